// File: doc/BRIEF.md
# Embedded Sync Decoder for 16-bit 4:2:2 Video

This block takes a parallel 16-bit video stream, one word per clock. The upper byte is the luma lane and the lower byte is the multiplexed chroma lane. The stream has no separate sync wires. Timing comes from reference codes embedded in the data. The block finds each code, checks its protection bits and turns it into level-type field, vertical-blanking and horizontal-blanking outputs. It marks the active 4:2:2 samples with a data-enable strobe and passes them through.

The block also reads the 11-bit line number that follows each end-of-active-video code. It checks that each line number is the successor of the last good one, wrapping at a configurable last line. A lock flag reports whether the end-of-active-video codes arrive at a steady spacing. Two one-cycle pulses report a corrupt status word and a bad or out-of-order line number.

Top module: `vid_sync_decoder`

## Requirements
- R1: While rst_n is low, every output is 0.
- R2: A code is four words: 16'hFFFF, 16'h0000, 16'h0000, then a status word whose two bytes are equal and whose bit 7 is 1. The status byte holds F in bit 6, V in bit 5 and H in bit 4. One cycle after an accepted status word, field_o, vsync_o and hsync_o show F, V and H.
- R3: A status word whose two lanes differ, or one not preceded by the exact three-word preamble, changes no output and raises no error.
- R4: The status byte bits 3..0 must equal {V^H, F^H, F^V, F^V^H}. On a mismatch, xyz_err_o pulses high for one cycle, one cycle after the word, and the code's flags are dropped.
- R5: After an accepted start code (H=0) with V=0, each following word that is not 16'hFFFF gives de_o=1 one cycle later, with pix_o equal to that word. pix_o changes only in such cycles.
- R6: de_o stays 0 from a 16'hFFFF word until the next accepted start code with V=0, so reference words and blanking never appear as pixels.
- R7: The two words after an accepted end code (H=1) carry the line number L as {~L[6],L[6:0]} and then {4'b1000,L[10:7]}, each in both lanes. One cycle after the second word, line_o shows L.
- R8: If a well-formed line number differs from the successor of the previous good number (LAST_LINE wraps to 1), line_err_o pulses for one cycle, with the same timing as R7. The first number after reset is never flagged.
- R9: If either line-number word is malformed (lanes differ, bit 7 of the first is not the inverse of bit 6, or the top nibble of the second is not 4'b1000), line_err_o pulses and line_o keeps its old value.
- R10: locked_o rises one cycle after an accepted end code that is spaced from the previous one by exactly the same number of words as that one was from its predecessor.
- R11: While locked, if no accepted end code arrives at the expected spacing, locked_o falls one cycle after that expected word. Regaining lock then needs two equal intervals again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_i | input | 16 | Video word, luma in [15:8], chroma in [7:0] |
| hsync_o | output | 1 | Horizontal blanking flag H from the last accepted code |
| vsync_o | output | 1 | Vertical blanking flag V from the last accepted code |
| field_o | output | 1 | Field flag F from the last accepted code |
| de_o | output | 1 | Active pixel strobe |
| pix_o | output | 16 | Last active pixel word |
| line_o | output | 11 | Last good decoded line number |
| xyz_err_o | output | 1 | Pulse: protection bits of a code are wrong |
| line_err_o | output | 1 | Pulse: line number is malformed or out of order |
| locked_o | output | 1 | End codes are arriving at a steady spacing |

## Verification
A corrupt preamble history or protection decode shows at the flag outputs and at xyz_err_o in the cycle right after the status word, and de_o then stays wrong for the rest of the line. A bad active state shows at de_o and pix_o one cycle after the first misjudged word. A stale previous line number shows as a false or missing line_err_o one cycle after the second line-number word of the next line. A bad spacing counter shows at locked_o no later than one line after the event. The bench compares all outputs against an independent model on every clock, so every such fault is caught within one line.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vsd_flags_t;

  // Expected protection nibble for a status byte
  function automatic logic [3:0] prot_bits(vsd_flags_t c);
    return {c.v ^ c.h, c.f ^ c.h, c.f ^ c.v, c.f ^ c.v ^ c.h};
  endfunction
endpackage

// File: rtl/vsd_trs_detect.sv
module vsd_trs_detect
  import vsd_pkg::*;
#(
  parameter int HIST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o,
  output logic              bad_o,
  output vsd_flags_t        flags_o
);
  logic [WORD_W-1:0] hist_q [HIST];
  logic [WORD_W-1:0] hist_d [HIST];
  logic pre_ok, lanes_eq, code_seen, prot_ok;

  always_comb begin
    hist_d[0] = word_i;
    for (int k = 1; k < HIST; k++) hist_d[k] = hist_q[k-1];
  end

  generate
    for (genvar g = 0; g < HIST; g++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q[g] <= '0;
        else        hist_q[g] <= hist_d[g];
      end
    end
  endgenerate

  // oldest word is the all-ones word, the newer ones are all zero
  always_comb begin
    pre_ok = (hist_q[HIST-1] == '1);
    for (int k = 0; k < HIST-1; k++)
      if (hist_q[k] != '0) pre_ok = 1'b0;
  end

  assign lanes_eq  = (word_i[WORD_W-1:LANE_W] == word_i[LANE_W-1:0]);
  assign code_seen = pre_ok && lanes_eq && word_i[LANE_W-1];
  assign flags_o   = vsd_flags_t'(word_i[LANE_W-2:LANE_W-4]);
  assign prot_ok   = (word_i[3:0] == prot_bits(flags_o));
  assign hit_o     = code_seen && prot_ok;
  assign bad_o     = code_seen && !prot_ok;
endmodule

// File: rtl/vsd_line_num.sv
module vsd_line_num
  import vsd_pkg::*;
#(
  parameter int LINE_W    = 11,
  parameter int LAST_LINE = 1125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eav_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [LINE_W-1:0] line_o,
  output logic              err_o
);
  localparam int LO_W = LANE_W - 1;
  localparam int HI_W = LINE_W - LO_W;
  localparam logic [LANE_W-HI_W-1:0] HI_MARK = {1'b1, {(LANE_W-HI_W-1){1'b0}}};

  typedef enum logic [1:0] {LN_IDLE, LN_LOW, LN_HIGH} ln_ph_t;

  ln_ph_t            ph_q, ph_d;
  logic [LO_W-1:0]   lo_q, lo_d;
  logic              fbad_q, fbad_d;
  logic [LINE_W-1:0] line_q, line_d, rx, succ;
  logic              pvld_q, pvld_d, err_q, err_d, lanes_eq;

  assign lanes_eq = (word_i[WORD_W-1:LANE_W] == word_i[LANE_W-1:0]);
  assign rx       = {word_i[HI_W-1:0], lo_q};
  assign succ     = (line_q == LINE_W'(LAST_LINE)) ? LINE_W'(1) : line_q + LINE_W'(1);

  always_comb begin
    ph_d   = ph_q;
    lo_d   = lo_q;
    fbad_d = fbad_q;
    line_d = line_q;
    pvld_d = pvld_q;
    err_d  = 1'b0;
    if (eav_i) begin
      ph_d = LN_LOW;
    end else begin
      case (ph_q)
        LN_LOW: begin
          lo_d   = word_i[LO_W-1:0];
          fbad_d = !lanes_eq || (word_i[LANE_W-1] == word_i[LANE_W-2]);
          ph_d   = LN_HIGH;
        end
        LN_HIGH: begin
          ph_d = LN_IDLE;
          if (fbad_q || !lanes_eq || (word_i[LANE_W-1:HI_W] != HI_MARK)) begin
            err_d = 1'b1;
          end else begin
            err_d  = pvld_q && (rx != succ);
            line_d = rx;
            pvld_d = 1'b1;
          end
        end
        default: ph_d = LN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= LN_IDLE;
      lo_q   <= '0;
      fbad_q <= 1'b0;
      line_q <= '0;
      pvld_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      lo_q   <= lo_d;
      fbad_q <= fbad_d;
      line_q <= line_d;
      pvld_q <= pvld_d;
      err_q  <= err_d;
    end
  end

  assign line_o = line_q;
  assign err_o  = err_q;
endmodule

// File: rtl/vsd_lock.sv
module vsd_lock #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eav_i,
  output logic locked_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d;
  logic pv_q, pv_d, seen_q, seen_d, lock_q, lock_d;

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    pv_d   = pv_q;
    seen_d = seen_q;
    lock_d = lock_q;
    if (eav_i) begin
      cnt_d = CNT_W'(1);
      if (seen_q) begin
        lock_d = pv_q && (cnt_q == per_q);
        per_d  = cnt_q;
        pv_d   = 1'b1;
      end
      seen_d = 1'b1;
    end else begin
      if (cnt_q != '1) cnt_d = cnt_q + CNT_W'(1);
      if (lock_q && (cnt_q == per_q)) begin
        lock_d = 1'b0;
        pv_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      pv_q   <= 1'b0;
      seen_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      pv_q   <= pv_d;
      seen_q <= seen_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder
  import vsd_pkg::*;
#(
  parameter int LINE_W         = 11,
  parameter int LAST_LINE      = 1125,
  parameter int MAX_LINE_WORDS = 4095
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       vid_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              de_o,
  output logic [15:0]       pix_o,
  output logic [LINE_W-1:0] line_o,
  output logic              xyz_err_o,
  output logic              line_err_o,
  output logic              locked_o
);
  localparam int CNT_W = $clog2(MAX_LINE_WORDS + 1);

  vsd_flags_t        code_fl, fl_q, fl_d;
  logic              hit, bad, eav, is_ones;
  logic              act_q, act_d, de_q, de_d, xerr_q;
  logic [WORD_W-1:0] pix_q, pix_d;

  vsd_trs_detect #(.HIST(3)) i_detect (
    .clk(clk), .rst_n(rst_n), .word_i(vid_i),
    .hit_o(hit), .bad_o(bad), .flags_o(code_fl)
  );

  assign eav     = hit && code_fl.h;
  assign is_ones = (vid_i == '1);

  vsd_line_num #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) i_line (
    .clk(clk), .rst_n(rst_n), .eav_i(eav), .word_i(vid_i),
    .line_o(line_o), .err_o(line_err_o)
  );

  vsd_lock #(.CNT_W(CNT_W)) i_lock (
    .clk(clk), .rst_n(rst_n), .eav_i(eav), .locked_o(locked_o)
  );

  always_comb begin
    fl_d  = hit ? code_fl : fl_q;
    de_d  = act_q && !is_ones;
    pix_d = de_d ? vid_i : pix_q;
    if (hit)          act_d = !code_fl.h && !code_fl.v;
    else if (is_ones) act_d = 1'b0;
    else              act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q   <= '0;
      act_q  <= 1'b0;
      de_q   <= 1'b0;
      pix_q  <= '0;
      xerr_q <= 1'b0;
    end else begin
      fl_q   <= fl_d;
      act_q  <= act_d;
      de_q   <= de_d;
      pix_q  <= pix_d;
      xerr_q <= bad;
    end
  end

  assign field_o   = fl_q.f;
  assign vsync_o   = fl_q.v;
  assign hsync_o   = fl_q.h;
  assign de_o      = de_q;
  assign pix_o     = pix_q;
  assign xyz_err_o = xerr_q;
endmodule

// File: rtl/vsd_checks.sv
module vsd_checks #(
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              field_o,
  input logic              de_o,
  input logic [15:0]       pix_o,
  input logic [LINE_W-1:0] line_o,
  input logic              xyz_err_o,
  input logic              line_err_o,
  input logic              locked_o
);
  a_r6_de_outside_blanking: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (!hsync_o && !vsync_o));

  a_r4_err_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    xyz_err_o |-> $stable({field_o, vsync_o, hsync_o}));

  a_r4_err_not_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    xyz_err_o |-> !de_o);

  a_r5_pix_moves_with_de: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_o) |-> de_o);

  a_r10_lock_at_end_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> hsync_o);

  a_r8_line_err_in_hblank: assert property (@(posedge clk) disable iff (!rst_n)
    line_err_o |-> (hsync_o && !de_o));

  a_r9_errors_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xyz_err_o, line_err_o}));

  a_r7_line_steady_without_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_o) |-> $stable(line_o));
endmodule

bind vid_sync_decoder vsd_checks #(.LINE_W(LINE_W)) i_vsd_checks (
  .clk(clk), .rst_n(rst_n), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .field_o(field_o), .de_o(de_o), .pix_o(pix_o), .line_o(line_o),
  .xyz_err_o(xyz_err_o), .line_err_o(line_err_o), .locked_o(locked_o)
);

// File: tb/test_vid_sync_decoder.sv
`timescale 1ns/1ps
module test_vid_sync_decoder;
  localparam int LAST = 1125;
  localparam int BLANK_W = 6;
  localparam int ACT_W = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] vid;
  logic hsync_o, vsync_o, field_o, de_o, xyz_err_o, line_err_o, locked_o;
  logic [15:0] pix_o;
  logic [10:0] line_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vid_sync_decoder i_vid_sync_decoder (
    .clk(clk), .rst_n(rst_n), .vid_i(vid), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .field_o(field_o), .de_o(de_o), .pix_o(pix_o), .line_o(line_o),
    .xyz_err_o(xyz_err_o), .line_err_o(line_err_o), .locked_o(locked_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] q[$];
  bit m_f, m_v, m_h, m_act, m_de, m_xerr, m_lerr, m_lock;
  logic [15:0] m_pix;
  int m_line, lphase, lo, prev, cyc, last_eav, per;
  bit lfmt_ok, prev_ok, seen, pv;

  function automatic int succ(input int p);
    return (p == LAST) ? 1 : p + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      {m_f, m_v, m_h, m_act, m_de, m_xerr, m_lerr, m_lock} = '0;
      m_pix = '0; m_line = 0; lphase = 0; lo = 0; prev = 0; prev_ok = 0;
      lfmt_ok = 0; cyc = 0; last_eav = 0; per = 0; seen = 0; pv = 0;
    end else begin
      logic [15:0] w;
      bit det, good, okc, eav, a, b, c;
      w = vid;
      det = (q.size() == 3) && q[2] == 16'hFFFF && q[1] == 16'h0 && q[0] == 16'h0 &&
            w[15:8] == w[7:0] && w[7];
      a = w[6]; b = w[5]; c = w[4];
      good = (w[3:0] == {b ^ c, a ^ c, a ^ b, a ^ b ^ c});
      m_xerr = det && !good;
      okc = det && good;
      eav = okc && c;
      m_de = m_act && (w != 16'hFFFF);
      if (m_de) m_pix = w;
      if (okc) begin
        m_f = a; m_v = b; m_h = c; m_act = !c && !b;
      end else if (w == 16'hFFFF) m_act = 0;
      m_lerr = 0;
      if (eav) lphase = 1;
      else if (lphase == 1) begin
        lo = w[6:0]; lfmt_ok = (w[15:8] == w[7:0]) && (w[7] != w[6]); lphase = 2;
      end else if (lphase == 2) begin
        lphase = 0;
        if (lfmt_ok && w[15:8] == w[7:0] && w[7:4] == 4'h8) begin
          int n;
          n = w[3:0] * 128 + lo;
          if (prev_ok && n != succ(prev)) m_lerr = 1;
          prev = n; prev_ok = 1; m_line = n;
        end else m_lerr = 1;
      end
      cyc++;
      if (eav) begin
        if (seen) begin
          m_lock = pv && ((cyc - last_eav) == per);
          per = cyc - last_eav; pv = 1;
        end
        seen = 1; last_eav = cyc;
      end else if (m_lock && (cyc - last_eav) == per) begin
        m_lock = 0; pv = 0;
      end
      q.push_front(w);
      if (q.size() > 3) void'(q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 field", field_o, m_f);
      chk("R2 vsync", vsync_o, m_v);
      chk("R2 hsync", hsync_o, m_h);
      chk("R5 R6 de", de_o, m_de);
      chk("R5 pix", pix_o, m_pix);
      chk("R7 line", line_o, m_line);
      chk("R8 line_err", line_err_o, m_lerr);
      chk("R4 xyz_err", xyz_err_o, m_xerr);
      chk("R10 R11 locked", locked_o, m_lock);
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [15:0] w);
    vid = w;
    @(negedge clk);
  endtask

  function automatic logic [7:0] xyz(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // mode 0 good, 1 bad protection, 2 lanes differ
  task automatic send_code(input bit f, input bit v, input bit h, input int mode);
    logic [7:0] s;
    s = xyz(f, v, h);
    put(16'hFFFF); put(16'h0000); put(16'h0000);
    if (mode == 1)      put({s ^ 8'h01, s ^ 8'h01});
    else if (mode == 2) put({s, s ^ 8'h02});
    else                put({s, s});
  endtask

  task automatic send_line(input int ln, input bit f, input bit v, input int eav_mode,
                           input int sav_mode, input bit ln_bad);
    logic [10:0] l;
    l = ln[10:0];
    send_code(f, v, 1'b1, eav_mode);
    put({2{~l[6], l[6:0]}});
    put(ln_bad ? {2{4'b0000, l[10:7]}} : {2{4'b1000, l[10:7]}});
    if (ln_bad) chk("R9 malformed line word flagged", line_err_o, 1'b1);
    for (int i = 0; i < BLANK_W; i++) put(16'h1080);
    send_code(f, v, 1'b0, sav_mode);
    if (sav_mode == 1) begin
      chk("R4 bad protection pulse", xyz_err_o, 1'b1);
      chk("R4 flags held", hsync_o, 1'b1);
    end else if (sav_mode == 2) begin
      chk("R3 lane mismatch no error", xyz_err_o, 1'b0);
      chk("R3 lane mismatch flags held", hsync_o, 1'b1);
    end
    for (int i = 0; i < ACT_W; i++)
      put(v ? 16'h1080 : {8'(16 + i * 7 + ln), 8'(128 + i)});
    if (sav_mode != 0) chk("R3 R4 ignored code gives no pixels", de_o, 1'b0);
    if (v && sav_mode == 0) chk("R6 no pixels in vertical blanking", de_o, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    vid = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 reset hsync", hsync_o, 0);
    chk("R1 reset vsync", vsync_o, 0);
    chk("R1 reset field", field_o, 0);
    chk("R1 reset de", de_o, 0);
    chk("R1 reset pix", pix_o, 0);
    chk("R1 reset line", line_o, 0);
    chk("R1 reset errs", {xyz_err_o, line_err_o}, 0);
    chk("R1 reset lock", locked_o, 0);
    rst_n = 1'b1;
    repeat (5) put(16'h1080);

    send_line(1121, 0, 1, 0, 0, 0);
    send_line(1122, 0, 1, 0, 0, 0);
    send_line(1123, 0, 0, 0, 0, 0);
    send_line(1124, 0, 0, 0, 0, 0);
    chk("R10 locked after equal intervals", locked_o, 1);
    send_line(1125, 0, 0, 0, 0, 0);
    send_line(1, 0, 0, 0, 0, 0);
    chk("R8 wrap gives no error", line_o, 1);
    send_line(2, 0, 0, 0, 1, 0);
    send_line(3, 0, 0, 0, 2, 0);
    send_line(4, 1, 0, 0, 0, 0);
    send_line(9, 1, 0, 0, 0, 0);
    send_line(10, 1, 0, 0, 0, 1);
    chk("R9 line number held", line_o, 9);
    send_line(11, 1, 0, 0, 0, 0);
    send_line(12, 1, 0, 1, 0, 0);
    repeat (6) put(16'h1080);
    chk("R11 lock lost on missing end code", locked_o, 0);
    send_line(13, 0, 0, 0, 0, 0);
    send_line(14, 0, 0, 0, 0, 0);
    chk("R11 not relocked after one interval", locked_o, 0);
    send_line(15, 0, 0, 0, 0, 0);
    chk("R10 relocked", locked_o, 1);
    send_line(16, 0, 1, 0, 0, 0);
    repeat (4) put(16'h1080);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule